// File: doc/BRIEF.md
# Sleep and Wake-up Controller

This block sequences power-down for a small microcontroller core. The instruction decoder hands it a strobe when a sleep instruction executes and another when a watchdog-clear instruction executes. The block decides whether the sleep really takes effect or collapses into a no-op. It holds the core clock while asleep and wakes the core when an enabled interrupt source or a watchdog timeout appears. It also keeps the two status bits that software reads back: a timeout bit and a power-down bit.

A wake-up source is active when its enable bit and its flag bit are both set. The global interrupt enable plays no part in that test. The block compares the state of the sources one cycle before the sleep strobe with the state in the strobe's own cycle. A source that was already active before the strobe turns the sleep into a no-op. A source that rises in the strobe cycle or later lets the sleep complete, and the core wakes on the next edge. The global enable only decides whether the wake-up also raises a request to jump to the interrupt vector.

The watchdog counter, instruction decode, vectoring datapath and oscillator sit outside this block.

Top module: `slumber_ctrl`

## Requirements
- R1: While `por` is high at a clock edge, `to_bit` and `pd_bit` become 1, and `clk_hold`, `wdt_clr`, `wake_pulse`, `irq_req` and `wdt_rst_req` become 0.
- R2: Source i counts as active only when both `src_en[i]` and `src_flag[i]` are 1. A flag without its enable neither blocks a sleep nor wakes the core. `gie` plays no part in this test.
- R3: If any source was active in the cycle before `sleep_stb`, the sleep is a no-op. `wdt_clr` stays 0, `clk_hold` stays 0, and `to_bit` and `pd_bit` keep their values.
- R4: A sleep that executes (no source active in the previous cycle, no `wdt_tmo`) gives, one edge later, `clk_hold`=1, `wdt_clr`=1 for exactly one cycle, `to_bit`=1 and `pd_bit`=0.
- R5: After a skipped sleep that follows power-on or a watchdog clear, `pd_bit` still reads 1.
- R6: `clrwdt_stb` while awake gives, one edge later, `wdt_clr`=1 for one cycle, `to_bit`=1 and `pd_bit`=1.
- R7: A source that becomes active in the same cycle as `sleep_stb`, or later, lets the sleep complete (R4). The core then wakes on the first edge at which a source is active while asleep. With no wake-up event, `clk_hold` stays 1.
- R8: A wake-up drops `clk_hold` on the same edge that raises `wake_pulse`, and `wake_pulse` lasts exactly one cycle.
- R9: `irq_req` pulses together with `wake_pulse` only when a source woke the core and `gie` was 1 at that edge. Otherwise it stays 0.
- R10: `wdt_tmo` while asleep wakes the core (R8) and clears `to_bit`. `pd_bit` stays 0.
- R11: `wdt_tmo` while awake pulses `wdt_rst_req` for one cycle and clears `to_bit`. `clk_hold` stays 0.
- R12: While asleep, `sleep_stb` and `clrwdt_stb` are ignored: `wdt_clr` stays 0 and `pd_bit` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| sleep_stb | input | 1 | Sleep instruction executes this cycle |
| clrwdt_stb | input | 1 | Watchdog-clear instruction executes this cycle |
| src_en | input | NSRC | Per-source wake-up enable bits |
| src_flag | input | NSRC | Per-source pending flags |
| gie | input | 1 | Global interrupt enable |
| wdt_tmo | input | 1 | Watchdog timeout pulse |
| to_bit | output | 1 | Timeout status bit (0 after a timeout) |
| pd_bit | output | 1 | Power-down status bit (0 after a real sleep) |
| wdt_clr | output | 1 | Clear pulse to watchdog and postscaler |
| clk_hold | output | 1 | Core clock held while asleep |
| wake_pulse | output | 1 | One-cycle wake-up pulse |
| irq_req | output | 1 | Interrupt vector request at wake-up |
| wdt_rst_req | output | 1 | Reset request after an awake timeout |

## Verification
The sleep strobe is driven against four source patterns. The first has a source that was already active one cycle earlier, which must collapse the sleep. The second has a source that rises in the strobe cycle itself, which must complete the sleep and then wake. The third has a flag with its enable clear, which must be treated as inactive. The fourth has no source at all, so only the watchdog can end the sleep. Running the wake-ups with `gie` both set and clear separates waking from vectoring. Strobes sent while asleep show that the halted core cannot disturb the status bits or the watchdog.

// File: rtl/slumber_pkg.sv
package slumber_pkg;

    typedef enum logic {
        ST_RUN   = 1'b0,
        ST_SLEEP = 1'b1
    } pd_state_e;

    // status update commands from the sequencer to the status register
    typedef struct packed {
        logic go_sleep;
        logic wdt_cleared;
        logic timeout;
    } stat_cmd_t;

    typedef struct packed {
        logic to_b;
        logic pd_b;
    } stat_bits_t;

    localparam stat_bits_t STAT_POR = '{to_b: 1'b1, pd_b: 1'b1};

    function automatic stat_bits_t stat_next(input stat_bits_t cur, input stat_cmd_t cmd);
        stat_bits_t nxt;
        nxt = cur;
        if (cmd.timeout) begin
            nxt.to_b = 1'b0;
        end else if (cmd.go_sleep) begin
            nxt.to_b = 1'b1;
            nxt.pd_b = 1'b0;
        end else if (cmd.wdt_cleared) begin
            nxt.to_b = 1'b1;
            nxt.pd_b = 1'b1;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/slumber_src_detect.sv
module slumber_src_detect #(
    parameter int NSRC = 4
) (
    input  logic            clk,
    input  logic            por,
    input  logic [NSRC-1:0] src_en,
    input  logic [NSRC-1:0] src_flag,
    output logic            active_now,
    output logic            active_prev
);
    logic [NSRC-1:0] live;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        assign live[i] = src_en[i] & src_flag[i];
    end

    assign active_now = |live;

    always_ff @(posedge clk) begin
        if (por) active_prev <= 1'b0;
        else     active_prev <= active_now;
    end

    // R2: the registered copy tracks the combined source state one edge later
    p_prev_tracks_r2: assert property (@(posedge clk) disable iff (por)
        (src_en & src_flag) != '0 |=> active_prev);

endmodule

// File: rtl/slumber_seq.sv
module slumber_seq
    import slumber_pkg::*;
(
    input  logic      clk,
    input  logic      por,
    input  logic      sleep_stb,
    input  logic      clrwdt_stb,
    input  logic      wdt_tmo,
    input  logic      gie,
    input  logic      active_now,
    input  logic      active_prev,
    output pd_state_e state,
    output stat_cmd_t cmd,
    output logic      wdt_clr,
    output logic      wake_pulse,
    output logic      irq_req,
    output logic      rst_req
);
    logic awake;
    logic sleep_go;
    logic wake_ev;

    assign awake    = (state == ST_RUN);
    assign sleep_go = awake && sleep_stb && !active_prev && !wdt_tmo;
    assign wake_ev  = !awake && (active_now || wdt_tmo);

    always_comb begin
        cmd.go_sleep    = sleep_go;
        cmd.wdt_cleared = awake && clrwdt_stb;
        cmd.timeout     = wdt_tmo;
    end

    always_ff @(posedge clk) begin
        if (por) begin
            state      <= ST_RUN;
            wdt_clr    <= 1'b0;
            wake_pulse <= 1'b0;
            irq_req    <= 1'b0;
            rst_req    <= 1'b0;
        end else begin
            wdt_clr    <= 1'b0;
            wake_pulse <= 1'b0;
            irq_req    <= 1'b0;
            rst_req    <= 1'b0;
            unique case (state)
                ST_RUN: begin
                    rst_req <= wdt_tmo;
                    wdt_clr <= sleep_go || clrwdt_stb;
                    if (sleep_go) state <= ST_SLEEP;
                end
                ST_SLEEP: begin
                    if (wake_ev) begin
                        state      <= ST_RUN;
                        wake_pulse <= 1'b1;
                        irq_req    <= gie && active_now;
                    end
                end
                default: state <= ST_RUN;
            endcase
        end
    end

    // R3: a pending source collapses the sleep
    p_skip_no_clear_r3: assert property (@(posedge clk) disable iff (por)
        (awake && sleep_stb && active_prev && !clrwdt_stb) |=> (!wdt_clr && state == ST_RUN));

    // R8: wake pulse is exactly one cycle
    p_wake_single_r8: assert property (@(posedge clk) disable iff (por)
        wake_pulse |=> !wake_pulse);

    // R9: vector request only at a wake-up with global enable set
    p_irq_needs_gie_r9: assert property (@(posedge clk) disable iff (por)
        irq_req |-> (wake_pulse && $past(gie)));

    // R11: awake timeout asks for a reset
    p_tmo_awake_r11: assert property (@(posedge clk) disable iff (por)
        (awake && wdt_tmo) |=> (rst_req && state == ST_RUN));

    // R12: strobes have no effect while asleep
    p_asleep_ignore_r12: assert property (@(posedge clk) disable iff (por)
        (!awake) |=> !wdt_clr);

endmodule

// File: rtl/slumber_status.sv
module slumber_status
    import slumber_pkg::*;
(
    input  logic       clk,
    input  logic       por,
    input  stat_cmd_t  cmd,
    output stat_bits_t stat
);
    always_ff @(posedge clk) begin
        if (por) stat <= STAT_POR;
        else     stat <= stat_next(stat, cmd);
    end

    // R10/R11: a timeout always leaves the timeout bit cleared
    p_tmo_clears_to_r10: assert property (@(posedge clk) disable iff (por)
        cmd.timeout |=> !stat.to_b);

    // R6: a watchdog clear with no timeout and no sleep sets both bits
    p_clr_sets_r6: assert property (@(posedge clk) disable iff (por)
        (cmd.wdt_cleared && !cmd.timeout && !cmd.go_sleep) |=> (stat.to_b && stat.pd_b));

endmodule

// File: rtl/slumber_ctrl.sv
module slumber_ctrl
    import slumber_pkg::*;
#(
    parameter int NSRC = 4
) (
    input  logic            clk,
    input  logic            por,
    input  logic            sleep_stb,
    input  logic            clrwdt_stb,
    input  logic [NSRC-1:0] src_en,
    input  logic [NSRC-1:0] src_flag,
    input  logic            gie,
    input  logic            wdt_tmo,
    output logic            to_bit,
    output logic            pd_bit,
    output logic            wdt_clr,
    output logic            clk_hold,
    output logic            wake_pulse,
    output logic            irq_req,
    output logic            wdt_rst_req
);
    logic       active_now;
    logic       active_prev;
    pd_state_e  state;
    stat_cmd_t  cmd;
    stat_bits_t stat;

    slumber_src_detect #(.NSRC(NSRC)) u_detect (
        .clk         (clk),
        .por         (por),
        .src_en      (src_en),
        .src_flag    (src_flag),
        .active_now  (active_now),
        .active_prev (active_prev)
    );

    slumber_seq u_seq (
        .clk         (clk),
        .por         (por),
        .sleep_stb   (sleep_stb),
        .clrwdt_stb  (clrwdt_stb),
        .wdt_tmo     (wdt_tmo),
        .gie         (gie),
        .active_now  (active_now),
        .active_prev (active_prev),
        .state       (state),
        .cmd         (cmd),
        .wdt_clr     (wdt_clr),
        .wake_pulse  (wake_pulse),
        .irq_req     (irq_req),
        .rst_req     (wdt_rst_req)
    );

    slumber_status u_status (
        .clk  (clk),
        .por  (por),
        .cmd  (cmd),
        .stat (stat)
    );

    assign to_bit   = stat.to_b;
    assign pd_bit   = stat.pd_b;
    assign clk_hold = (state == ST_SLEEP);

    // R4: entering sleep always comes with a watchdog clear
    p_enter_clears_r4: assert property (@(posedge clk) disable iff (por)
        $rose(clk_hold) |-> (wdt_clr && !pd_bit && to_bit));

    // R4: power-down bit only falls when the core really goes to sleep
    p_pd_fall_sleep_r4: assert property (@(posedge clk) disable iff (por)
        $fell(pd_bit) |-> clk_hold);

    // R8: wake pulse coincides with release of the clock hold
    p_wake_release_r8: assert property (@(posedge clk) disable iff (por)
        wake_pulse |-> (!clk_hold && $past(clk_hold)));

endmodule

// File: tb/slumber_ctrl_test.sv
module slumber_ctrl_test;
    localparam int NSRC = 4;

    logic            clk = 1'b0;
    logic            por;
    logic            sleep_stb, clrwdt_stb, gie, wdt_tmo;
    logic [NSRC-1:0] src_en, src_flag;
    logic            to_bit, pd_bit, wdt_clr, clk_hold, wake_pulse, irq_req, wdt_rst_req;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    slumber_ctrl #(.NSRC(NSRC)) uut (
        .clk(clk), .por(por), .sleep_stb(sleep_stb), .clrwdt_stb(clrwdt_stb),
        .src_en(src_en), .src_flag(src_flag), .gie(gie), .wdt_tmo(wdt_tmo),
        .to_bit(to_bit), .pd_bit(pd_bit), .wdt_clr(wdt_clr), .clk_hold(clk_hold),
        .wake_pulse(wake_pulse), .irq_req(irq_req), .wdt_rst_req(wdt_rst_req)
    );

    task automatic chk(input string tag, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    // drive at the falling edge, let one rising edge pass, sample at the next falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        sleep_stb  = 1'b0;
        clrwdt_stb = 1'b0;
        wdt_tmo    = 1'b0;
    endtask

    task automatic quiet();
        src_en = '0; src_flag = '0; gie = 1'b0;
        step();
        step();
    endtask

    task automatic t_reset();
        chk("R1 to", to_bit, 1'b1);
        chk("R1 pd", pd_bit, 1'b1);
        chk("R1 hold", clk_hold, 1'b0);
        chk("R1 wdt_clr", wdt_clr, 1'b0);
        chk("R1 wake", wake_pulse, 1'b0);
        chk("R1 irq", irq_req, 1'b0);
        chk("R1 rst_req", wdt_rst_req, 1'b0);
    endtask

    task automatic t_clrwdt();
        clrwdt_stb = 1'b1;
        step();
        chk("R6 wdt_clr", wdt_clr, 1'b1);
        chk("R6 to", to_bit, 1'b1);
        chk("R6 pd", pd_bit, 1'b1);
        step();
        chk("R6 wdt_clr one cycle", wdt_clr, 1'b0);
    endtask

    task automatic t_tmo_awake();
        wdt_tmo = 1'b1;
        step();
        chk("R11 rst_req", wdt_rst_req, 1'b1);
        chk("R11 to", to_bit, 1'b0);
        chk("R11 hold", clk_hold, 1'b0);
        step();
        chk("R11 rst_req one cycle", wdt_rst_req, 1'b0);
    endtask

    task automatic t_skip();
        // source already pending with gie clear; to is 0 from the timeout test
        src_en = 4'b0010; src_flag = 4'b0010; gie = 1'b0;
        step();
        sleep_stb = 1'b1;
        step();
        chk("R3 no wdt_clr", wdt_clr, 1'b0);
        chk("R3 no hold", clk_hold, 1'b0);
        chk("R3 to unchanged", to_bit, 1'b0);
        chk("R5 pd still 1", pd_bit, 1'b1);
        chk("R2 gie ignored", wake_pulse, 1'b0);
        quiet();
    endtask

    task automatic t_sleep_wake_irq();
        sleep_stb = 1'b1;
        step();
        chk("R4 hold", clk_hold, 1'b1);
        chk("R4 wdt_clr", wdt_clr, 1'b1);
        chk("R4 to", to_bit, 1'b1);
        chk("R4 pd", pd_bit, 1'b0);
        step();
        chk("R4 wdt_clr one cycle", wdt_clr, 1'b0);
        chk("R7 stays asleep", clk_hold, 1'b1);
        clrwdt_stb = 1'b1;
        sleep_stb  = 1'b1;
        step();
        chk("R12 no wdt_clr", wdt_clr, 1'b0);
        chk("R12 pd stays 0", pd_bit, 1'b0);
        chk("R12 still asleep", clk_hold, 1'b1);
        gie = 1'b1; src_en = 4'b1000; src_flag = 4'b1000;
        step();
        chk("R8 hold released", clk_hold, 1'b0);
        chk("R8 wake", wake_pulse, 1'b1);
        chk("R9 irq with gie", irq_req, 1'b1);
        step();
        chk("R8 wake one cycle", wake_pulse, 1'b0);
        chk("R9 irq one cycle", irq_req, 1'b0);
        quiet();
    endtask

    task automatic t_same_cycle();
        gie = 1'b0;
        sleep_stb = 1'b1;
        src_en = 4'b0001; src_flag = 4'b0001;
        step();
        chk("R7 sleep completes hold", clk_hold, 1'b1);
        chk("R7 sleep completes wdt_clr", wdt_clr, 1'b1);
        chk("R7 sleep completes pd", pd_bit, 1'b0);
        step();
        chk("R7 woke", clk_hold, 1'b0);
        chk("R7 wake pulse", wake_pulse, 1'b1);
        chk("R9 no irq without gie", irq_req, 1'b0);
        quiet();
    endtask

    task automatic t_flag_no_enable();
        src_en = 4'b0000; src_flag = 4'b0100;
        step();
        sleep_stb = 1'b1;
        step();
        chk("R2 flag alone does not block", clk_hold, 1'b1);
        step();
        chk("R2 flag alone does not wake", clk_hold, 1'b1);
        src_en = 4'b0100;
        step();
        chk("R2 enabled flag wakes", wake_pulse, 1'b1);
        quiet();
    endtask

    task automatic t_tmo_asleep();
        sleep_stb = 1'b1;
        step();
        chk("R10 asleep", clk_hold, 1'b1);
        wdt_tmo = 1'b1;
        gie = 1'b1;
        step();
        chk("R10 wake", wake_pulse, 1'b1);
        chk("R10 hold released", clk_hold, 1'b0);
        chk("R10 to cleared", to_bit, 1'b0);
        chk("R10 pd stays 0", pd_bit, 1'b0);
        chk("R10 no irq", irq_req, 1'b0);
        chk("R10 no rst_req", wdt_rst_req, 1'b0);
        quiet();
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        por = 1'b1; sleep_stb = 1'b0; clrwdt_stb = 1'b0; gie = 1'b0; wdt_tmo = 1'b0;
        src_en = '0; src_flag = '0;
        @(negedge clk);
        step();
        step();
        por = 1'b0;
        t_reset();
        t_clrwdt();
        t_tmo_awake();
        t_skip();
        t_sleep_wake_irq();
        t_same_cycle();
        t_flag_no_enable();
        t_tmo_asleep();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule